// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. N may be 8, 16, 32 or 64. The core is an 8x8 cell. It first forms every AND term x[i]&y[j] at once, with no addition in that step. For each output column k it then adds the terms whose indices sum to k, together with the carry that arrives from the column below. The low bit of that column total becomes product bit k, and the rest moves up as carry. There are 2N-1 such column sums, and they have different widths. When the last column has been summed, the leftover carry gives the top product bit, and any carry above that bit is dropped.

Widths above 8 bits use recursion. Each operand is split into a high half and a low half. Four half-width multipliers form the four cross products, and these are aligned and summed at 2N bits. A parameter selects whether the product is presented combinationally or through one output register with a synchronous active-high reset.

Top module: `vcm_mult`

## Requirements
- R1: `p` equals the unsigned product of `a` and `b`, zero-extended to 2N bits, for every operand pair and for every supported N (8, 16, 32, 64).
- R2: With `REG_OUT=1`, `p` shows the product of the operands sampled at the previous rising clock edge. If the operands do not change, `p` does not change either.
- R3: With `REG_OUT=0`, `p` follows `a` and `b` combinationally, with no clock involved.
- R4: With `REG_OUT=1`, `p` reads all zeros after any rising edge at which `rst` is high, whatever values the operands hold.
- R5: If either operand is zero, the product is zero.
- R6: The upper N bits of `p` are never all ones. The largest possible product, (2^N-1)^2, has upper half 2^N-2 and lower half 1.
- R7: If one operand is 1, `p` equals the other operand zero-extended to 2N bits.
- R8: Swapping the two operands gives the same product.
- R9: The 8-bit configuration returns the correct 16-bit product for all 65,536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset; clears the output register |
| a | input | W | Unsigned multiplicand |
| b | input | W | Unsigned multiplier |
| p | output | 2*W | Unsigned product |

## Verification
The bench builds two instances. The first uses W=64 with the output register enabled. It runs through three levels of recursion, exercises the one-cycle latency and the reset clear, and is driven with random operands plus zero, one, all-ones and half-boundary values. The second uses W=8 with no register, so the base cell stands alone and can be checked exhaustively, together with the combinational output path.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Width of the leaf cell that performs the column-sum method directly.
  localparam int BASE_W = 8;
endpackage

// File: rtl/vcm_base.sv
// Leaf multiplier: all AND terms are formed first, then each column is summed
// together with the carry coming up from the column below it.
module vcm_base #(
  parameter int BW = 8
) (
  input  logic [BW-1:0]   x,
  input  logic [BW-1:0]   y,
  output logic [2*BW-1:0] prod
);
  localparam int COLS = 2*BW - 1;
  localparam int AW   = $clog2(2*BW) + 1;
  localparam int LW   = (BW > 1) ? $clog2(BW) : 1;

  // row[j][i] = x[i] & y[j]; generated in parallel, no addition yet
  logic [BW-1:0] row [BW];

  genvar gj;
  generate
    for (gj = 0; gj < BW; gj++) begin : g_terms
      assign row[gj] = x & {BW{y[gj]}};
    end
  endgenerate

  logic [AW-1:0] acc;
  logic [AW-2:0] carry;
  logic [LW-1:0] idx;

  always_comb begin
    carry = '0;
    prod  = '0;
    acc   = '0;
    idx   = '0;
    for (int k = 0; k < COLS; k++) begin
      acc = AW'(carry);
      for (int j = 0; j < BW; j++) begin
        if ((k - j) >= 0 && (k - j) < BW) begin
          idx = LW'(k - j);
          acc = acc + AW'(row[j][idx]);
        end
      end
      prod[k] = acc[0];
      carry   = acc[AW-1:1];
    end
    // last column's carry forms the top bit; anything higher is redundant
    prod[2*BW-1] = carry[0];
  end
endmodule

// File: rtl/vcm_tile.sv
// Recursive tile: a leaf cell at the base width, otherwise four half-width
// tiles whose cross products are aligned and summed at full width.
module vcm_tile
  import vcm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  generate
    if (W <= BASE_W) begin : g_leaf
      vcm_base #(.BW(W)) u_leaf (.x(a), .y(b), .prod(p));
    end else begin : g_split
      localparam int H = W / 2;
      logic [W-1:0] q_ll, q_lh, q_hl, q_hh;

      vcm_tile #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));
      vcm_tile #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(q_lh));
      vcm_tile #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(q_hl));
      vcm_tile #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(q_hh));

      assign p = {{W{1'b0}}, q_ll}
               + {{H{1'b0}}, q_lh, {H{1'b0}}}
               + {{H{1'b0}}, q_hl, {H{1'b0}}}
               + {q_hh, {W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/vcm_mult.sv
// Top level: recursive multiplier with an optional registered product.
module vcm_mult #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  logic [2*W-1:0] raw;

  vcm_tile #(.W(W)) u_core (.a(a), .b(b), .p(raw));

  generate
    if (REG_OUT) begin : g_reg
      logic [2*W-1:0] p_q;
      always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= raw;
      end
      assign p = p_q;
    end else begin : g_comb
      assign p = raw;
    end
  endgenerate
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    p[PW-1:W] != {W{1'b1}}); // R6

  generate
    if (REG_OUT) begin : g_seq
      AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> p == (PW'($past(a)) * PW'($past(b)))); // R1
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(a) && $stable(b) && !$past(rst)) |=> $stable(p)); // R2
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a == '0 || b == '0) |=> p == '0); // R5
      AST_ONE_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a == W'(1)) |=> p == PW'($past(b))); // R7
      AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> p == '0); // R4
    end else begin : g_comb
      AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        p == (PW'(a) * PW'(b))); // R3
      AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a == '0 || b == '0) |-> p == '0); // R5
      AST_ONE_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a == W'(1)) |-> p == PW'(b)); // R7
    end
  endgenerate
endmodule

bind vcm_mult vcm_mult_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .p(p)
);

// File: tb/vcm_mult_test.sv
`timescale 1ns/100ps
module vcm_mult_test;
  localparam int W = 64;

  typedef struct {
    logic [2*W-1:0] exp;
    logic [W-1:0]   opa;
    logic [W-1:0]   opb;
    string          tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]   a = '0, b = '0;
  logic [2*W-1:0] p;
  logic [7:0]     a8 = '0, b8 = '0;
  logic [15:0]    p8;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  vcm_mult #(.W(W), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .p(p));

  vcm_mult #(.W(8), .REG_OUT(1'b0)) uut8 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .p(p8));

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
    logic [2*W-1:0] xx, yy;
    xx = {{W{1'b0}}, x};
    yy = {{W{1'b0}}, y};
    return xx * yy;
  endfunction

  // Driver: presents operands at a falling edge and queues the expectation.
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    @(negedge clk);
    a = x;
    b = y;
    it.exp = ref_mul(x, y);
    it.opa = x;
    it.opb = y;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: one register stage, so the result is visible just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_tests++;
        if (p !== it.exp) begin
          n_fail++;
          $display("FAIL %s a=%h b=%h actual=%h expected=%h", it.tag, it.opa, it.opb, p, it.exp);
        end
      end
    end
  end

  task automatic check_direct(input string tag, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones;
    ones = '1;
    // R4: reset state
    repeat (3) @(negedge clk);
    check_direct("R4 reset value", p, '0);
    @(negedge clk);
    rst = 1'b0;

    // R5 zero operands
    drive('0, 64'h0123_4567_89ab_cdef, "R5 zero a");
    drive(64'hfedc_ba98_7654_3210, '0, "R5 zero b");
    // R7 unit operands
    drive(64'd1, 64'hdead_beef_cafe_f00d, "R7 one a");
    drive(ones, 64'd1, "R7 one b");
    // R6 largest product
    drive(ones, ones, "R6 all ones");
    // R1 half-boundary and pattern values crossing recursion seams
    drive(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, "R1 half boundary");
    drive(64'h0000_0000_ffff_ffff, 64'hffff_ffff_0000_0000, "R1 split halves");
    drive(64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555, "R1 alternating");
    drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R1 top bits");
    drive(64'h0000_0000_0000_00ff, 64'h0000_0000_0000_00ff, "R1 leaf only");
    // R8 commutativity
    drive(64'h1357_9bdf_2468_ace0, 64'h0f0f_1234_ffff_0001, "R8 order ab");
    drive(64'h0f0f_1234_ffff_0001, 64'h1357_9bdf_2468_ace0, "R8 order ba");
    // R1 random
    for (int i = 0; i < 400; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, "R1 random");
    end
    // R2 hold: same operands over several cycles keep the product steady
    for (int i = 0; i < 4; i++) begin
      drive(64'h7777_0000_1234_5678, 64'h0000_9999_8765_4321, "R2 hold");
    end
    wait (q.size() == 0);
    @(negedge clk);

    // R4: reset with live operands clears the register
    a = ones;
    b = ones;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_direct("R4 reset clears", p, '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_direct("R2 after reset release", p, ref_mul(ones, ones));

    // R9 and R3: exhaustive 8-bit, combinational path
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        a8 = 8'(x);
        b8 = 8'(y);
        #0.5;
        n_tests++;
        if (p8 !== 16'(x * y)) begin
          n_fail++;
          $display("FAIL R9/R3 a=%0d b=%0d actual=%h expected=%h", x, y, p8, 16'(x * y));
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule